// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block reads an adapter's start-up settings from a two-wire serial EEPROM by toggling the clock and data lines one register write at a time. Each write sets an output enable together with the wanted clock and data levels, then holds them for a fixed settle interval before the next write. The returned data line is sampled from an input.

Once the glue logic is enabled, a sequencer performs eight single-byte random reads. These fetch the ring-speed byte, the RAM-size byte and six station-address bytes. From them it derives a speed-select bit, the RAM size in kilobytes and a 48-bit station address. A device that stays silent gets the start-plus-command sequence retried. A byte that cannot be read comes back as 0xFF, and its field is flagged. A single done pulse closes the load.

Top module: `seeprom_cfg_loader`

## Requirements
- R1: Out of reset the lines are enable 0, clock 0, data 1. Every line write drives `line_en_o` to 1, so no line level changes while enable is low after the first write.
- R2: Each line write is held for exactly SETTLE_CYCLES+1 clock cycles before the next write can change the lines.
- R3: A start condition is four writes, as (clock,data) pairs: (0,1), (1,1), (1,0), (0,1). While the clock stays high, data may only fall.
- R4: A transmitted bit is three writes with data constant: clock low, high, low. Bytes go most significant bit first. The write command is {DEV_SEL,0} (0xA0 by default) and the read command is {DEV_SEL,1} (0xA1).
- R5: A received bit is four writes with data driven 1: clock low, high, high, low. `sda_i` is sampled at the end of the second write's hold time. Data bits arrive most significant first.
- R6: An acknowledge is accepted in the first of up to MAX_SLOTS successive received bit slots that reads 0. If no slot reads 0, the acknowledge fails.
- R7: A command byte is sent up to MAX_TRIES times, each attempt preceded by a start condition, until it is acknowledged.
- R8: A read is: write command, word address with one acknowledge poll, read command, eight data bits, then a poll that must see a 1 within MAX_SLOTS slots. Any failure yields byte 0xFF and sets that field's bit of `field_err_o` (bit 0 speed, bit 1 RAM size, bit 2 any address byte).
- R9: `speed_4m_o` is 1 when the ring-speed byte is nonzero (4 Mbit/s) and 0 when it is zero (16 Mbit/s).
- R10: `ram_kb_o` equals the RAM-size byte times 128.
- R11: The station address is read from ADDR_BYTES consecutive EEPROM words starting at ADDR_BASE. The byte at ADDR_BASE lands in bits [47:40].
- R12: No line is written before `glue_en` is high. `cfg_done_o` pulses for one cycle after the last read, and no further reads follow until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glue_en | input | 1 | Glue logic enabled; starts the load |
| sda_i | input | 1 | Sampled level of the serial data line |
| line_en_o | output | 1 | Line driver enable |
| scl_o | output | 1 | Serial clock level |
| sda_o | output | 1 | Serial data level driven by the master |
| speed_4m_o | output | 1 | 1 selects 4 Mbit/s, 0 selects 16 Mbit/s |
| ram_kb_o | output | RAM_KB_W | Adapter RAM size in kilobytes |
| station_addr_o | output | 8*ADDR_BYTES | Station address, first byte most significant |
| field_err_o | output | 3 | Per-field read failure flags |
| cfg_done_o | output | 1 | One-cycle pulse when the load is complete |

## Verification
The assertions assume the EEPROM never stretches the clock and only changes `sda_i` while the master holds the clock low. They also assume `glue_en` stays high once raised. The bench EEPROM model respects this: it updates its pull-down only on falling clock edges it observes, and it stops pulling after a start condition. Its knobs (acknowledge slots withheld, command acknowledges refused, stuck data after a byte) drive the retry and failure paths without breaking these conditions.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   typedef struct packed {
      logic scl;
      logic sda;
   } line_t;

   typedef enum logic [2:0] {
      E_IDLE, E_START, E_TX, E_ACK, E_RXD, E_NACK, E_FIN
   } eng_state_t;

   typedef enum logic [1:0] {
      STG_CMDW, STG_ADDR, STG_CMDR
   } stage_t;

   typedef enum logic [1:0] {
      L_WAIT, L_ISSUE, L_BUSY, L_END
   } ld_state_t;
endpackage

// File: rtl/twl_line_pacer.sv
module twl_line_pacer
   import seeprom_pkg::*;
#(
   parameter int SETTLE_CYCLES = 20
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  fire,
   input  line_t want,
   output logic  step_done,
   output logic  en_o,
   output logic  scl_o,
   output logic  sda_o
);
   localparam int CW = $clog2(SETTLE_CYCLES + 1);

   logic [CW-1:0] cnt;
   logic          busy;

   assign step_done = busy && (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         busy  <= 1'b0;
         en_o  <= 1'b0;
         scl_o <= 1'b0;
         sda_o <= 1'b1;
      end else if (fire && !busy) begin
         en_o  <= 1'b1;
         scl_o <= want.scl;
         sda_o <= want.sda;
         cnt   <= CW'(SETTLE_CYCLES);
         busy  <= 1'b1;
      end else if (busy) begin
         cnt <= cnt - CW'(1);
         if (cnt == CW'(1)) busy <= 1'b0;
      end
   end

   AST_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !busy); // R2
   AST_EN_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o != $past(scl_o)) || (sda_o != $past(sda_o)) |-> en_o); // R1
   AST_HIGH_DATA_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      scl_o && $past(scl_o) && (sda_o != $past(sda_o)) |-> !sda_o); // R3
endmodule

// File: rtl/twl_byte_reader.sv
module twl_byte_reader
   import seeprom_pkg::*;
#(
   parameter int       MAX_TRIES = 10,
   parameter int       MAX_SLOTS = 10,
   parameter bit [6:0] DEV_SEL   = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] addr,
   input  logic       step_done,
   input  logic       sda_i,
   output logic       fire,
   output line_t      want,
   output logic       done,
   output logic       err,
   output logic [7:0] byte_o
);
   localparam int       TW     = $clog2(MAX_TRIES + 1);
   localparam int       SW     = $clog2(MAX_SLOTS + 1);
   localparam bit [7:0] WR_CMD = {DEV_SEL, 1'b0};
   localparam bit [7:0] RD_CMD = {DEV_SEL, 1'b1};

   eng_state_t    st;
   stage_t        stg;
   logic [1:0]    ph;
   logic [2:0]    bitn;
   logic [TW-1:0] tries;
   logic [SW-1:0] slots;
   logic [7:0]    shreg, rx, addr_q;
   logic          smp, pend, err_q;
   logic          last_slot;

   assign last_slot = (slots == SW'(MAX_SLOTS - 1));
   assign fire = !pend && (st inside {E_START, E_TX, E_ACK, E_RXD, E_NACK});

   always_comb begin
      want.scl = 1'b0;
      want.sda = 1'b1;
      unique case (st)
         E_START: begin
            want.scl = (ph == 2'd1) || (ph == 2'd2);
            want.sda = (ph != 2'd2);
         end
         E_TX: begin
            want.scl = (ph == 2'd1);
            want.sda = shreg[7];
         end
         E_ACK, E_RXD, E_NACK: want.scl = (ph == 2'd1) || (ph == 2'd2);
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= E_IDLE; stg <= STG_CMDW; ph <= '0; bitn <= '0;
         tries <= '0; slots <= '0; shreg <= '0; rx <= '0; addr_q <= '0;
         smp <= 1'b1; pend <= 1'b0; err_q <= 1'b0;
         done <= 1'b0; err <= 1'b0; byte_o <= 8'hFF;
      end else begin
         done <= 1'b0;
         if (fire) pend <= 1'b1;
         if (step_done) pend <= 1'b0;
         unique case (st)
            E_IDLE: if (go) begin
               st <= E_START; stg <= STG_CMDW; tries <= '0;
               ph <= '0; addr_q <= addr; err_q <= 1'b0;
            end
            E_START: if (step_done) begin
               if (ph == 2'd3) begin
                  ph <= '0; st <= E_TX; bitn <= 3'd7;
                  shreg <= (stg == STG_CMDR) ? RD_CMD : WR_CMD;
               end else ph <= ph + 2'd1;
            end
            E_TX: if (step_done) begin
               if (ph == 2'd2) begin
                  ph <= '0;
                  if (bitn == 3'd0) begin
                     st <= E_ACK; slots <= '0;
                  end else begin
                     bitn <= bitn - 3'd1; shreg <= {shreg[6:0], 1'b0};
                  end
               end else ph <= ph + 2'd1;
            end
            E_ACK, E_RXD, E_NACK: if (step_done) begin
               if (ph == 2'd1) smp <= sda_i;
               if (ph != 2'd3) ph <= ph + 2'd1;
               else begin
                  ph <= '0;
                  if (st == E_RXD) begin
                     rx <= {rx[6:0], smp};
                     if (bitn == 3'd0) begin
                        st <= E_NACK; slots <= '0;
                     end else bitn <= bitn - 3'd1;
                  end else if (st == E_NACK) begin
                     if (smp) st <= E_FIN;
                     else if (last_slot) begin st <= E_FIN; err_q <= 1'b1; end
                     else slots <= slots + SW'(1);
                  end else if (!smp) begin
                     unique case (stg)
                        STG_CMDW: begin
                           st <= E_TX; stg <= STG_ADDR; shreg <= addr_q; bitn <= 3'd7;
                        end
                        STG_ADDR: begin
                           st <= E_START; stg <= STG_CMDR; tries <= '0;
                        end
                        default: begin st <= E_RXD; bitn <= 3'd7; end
                     endcase
                  end else if (!last_slot) slots <= slots + SW'(1);
                  else if (stg == STG_ADDR || tries == TW'(MAX_TRIES - 1)) begin
                     st <= E_FIN; err_q <= 1'b1;
                  end else begin
                     st <= E_START; tries <= tries + TW'(1);
                  end
               end
            end
            default: begin
               done   <= 1'b1;
               err    <= err_q;
               byte_o <= err_q ? 8'hFF : rx;
               st     <= E_IDLE;
            end
         endcase
      end
   end

   AST_NO_STEP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |-> pend); // R2
   AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> st == E_IDLE); // R12
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
   import seeprom_pkg::*;
#(
   parameter bit [7:0] SPEED_ADDR = 8'h02,
   parameter bit [7:0] RAM_ADDR   = 8'h03,
   parameter bit [7:0] ADDR_BASE  = 8'h08,
   parameter int       ADDR_BYTES = 6,
   parameter int       RAM_KB_W   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    glue_en,
   input  logic                    rd_done,
   input  logic                    rd_err,
   input  logic [7:0]              rd_byte,
   output logic                    rd_go,
   output logic [7:0]              rd_addr,
   output logic                    speed_4m,
   output logic [RAM_KB_W-1:0]     ram_kb,
   output logic [8*ADDR_BYTES-1:0] station,
   output logic [2:0]              field_err,
   output logic                    cfg_done
);
   localparam int N_READS = 2 + ADDR_BYTES;
   localparam int IW      = $clog2(N_READS);

   ld_state_t     lst;
   logic [IW-1:0] idx;

   assign rd_go = (lst == L_ISSUE);

   always_comb begin
      if (idx == IW'(0))      rd_addr = SPEED_ADDR;
      else if (idx == IW'(1)) rd_addr = RAM_ADDR;
      else                    rd_addr = ADDR_BASE + 8'(idx) - 8'd2;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lst <= L_WAIT; idx <= '0; speed_4m <= 1'b0; ram_kb <= '0;
         field_err <= '0; cfg_done <= 1'b0;
      end else begin
         cfg_done <= 1'b0;
         unique case (lst)
            L_WAIT:  if (glue_en) lst <= L_ISSUE;
            L_ISSUE: lst <= L_BUSY;
            L_BUSY: if (rd_done) begin
               if (idx == IW'(0)) begin
                  speed_4m     <= (rd_byte != 8'h00);
                  field_err[0] <= rd_err;
               end else if (idx == IW'(1)) begin
                  ram_kb       <= RAM_KB_W'({rd_byte, 7'b0});
                  field_err[1] <= rd_err;
               end else if (rd_err) field_err[2] <= 1'b1;
               if (idx == IW'(N_READS - 1)) begin
                  lst <= L_END; cfg_done <= 1'b1;
               end else begin
                  idx <= idx + IW'(1); lst <= L_ISSUE;
               end
            end
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
         if (!rst_n) b_q <= '0;
         else if (lst == L_BUSY && rd_done && idx == IW'(g + 2)) b_q <= rd_byte;
      end
      assign station[8*(ADDR_BYTES-1-g) +: 8] = b_q;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> !cfg_done); // R12
   AST_ERR_SPEED_4M: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done && field_err[0] |-> speed_4m); // R9
   AST_NO_READ_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      lst == L_END |=> !rd_go); // R12
endmodule

// File: rtl/seeprom_cfg_loader.sv
module seeprom_cfg_loader
   import seeprom_pkg::*;
#(
   parameter int       SETTLE_CYCLES = 20,
   parameter int       MAX_TRIES     = 10,
   parameter int       MAX_SLOTS     = 10,
   parameter bit [6:0] DEV_SEL       = 7'h50,
   parameter bit [7:0] SPEED_ADDR    = 8'h02,
   parameter bit [7:0] RAM_ADDR      = 8'h03,
   parameter bit [7:0] ADDR_BASE     = 8'h08,
   parameter int       ADDR_BYTES    = 6,
   parameter int       RAM_KB_W      = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    glue_en,
   input  logic                    sda_i,
   output logic                    line_en_o,
   output logic                    scl_o,
   output logic                    sda_o,
   output logic                    speed_4m_o,
   output logic [RAM_KB_W-1:0]     ram_kb_o,
   output logic [8*ADDR_BYTES-1:0] station_addr_o,
   output logic [2:0]              field_err_o,
   output logic                    cfg_done_o
);
   if (SETTLE_CYCLES < 2) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 2");
   end
   if (MAX_TRIES < 1 || MAX_SLOTS < 1) begin : g_bad_limits
      $error("retry and slot limits must be at least 1");
   end
   if (RAM_KB_W < 15) begin : g_bad_ramw
      $error("RAM_KB_W must hold 255*128");
   end
   if (ADDR_BYTES < 1) begin : g_bad_addr
      $error("ADDR_BYTES must be at least 1");
   end

   logic       fire, step_done, rd_go, rd_done, rd_err;
   line_t      want;
   logic [7:0] rd_addr, rd_byte;

   twl_line_pacer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pacer (
      .clk(clk), .rst_n(rst_n), .fire(fire), .want(want),
      .step_done(step_done), .en_o(line_en_o), .scl_o(scl_o), .sda_o(sda_o));

   twl_byte_reader #(.MAX_TRIES(MAX_TRIES), .MAX_SLOTS(MAX_SLOTS), .DEV_SEL(DEV_SEL)) u_reader (
      .clk(clk), .rst_n(rst_n), .go(rd_go), .addr(rd_addr), .step_done(step_done),
      .sda_i(sda_i), .fire(fire), .want(want), .done(rd_done), .err(rd_err),
      .byte_o(rd_byte));

   cfg_sequencer #(.SPEED_ADDR(SPEED_ADDR), .RAM_ADDR(RAM_ADDR), .ADDR_BASE(ADDR_BASE),
                   .ADDR_BYTES(ADDR_BYTES), .RAM_KB_W(RAM_KB_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .glue_en(glue_en), .rd_done(rd_done), .rd_err(rd_err),
      .rd_byte(rd_byte), .rd_go(rd_go), .rd_addr(rd_addr), .speed_4m(speed_4m_o),
      .ram_kb(ram_kb_o), .station(station_addr_o), .field_err(field_err_o),
      .cfg_done(cfg_done_o));
endmodule

// File: tb/sim_seeprom_cfg_loader.sv
module sim_seeprom_cfg_loader;
   localparam int TB_SETTLE = 4;
   localparam logic [7:0] SP_A = 8'h02, RAM_A = 8'h03, MAC_A = 8'h08;
   // row: refuse, withhold, stuck, speed byte, ram byte
   localparam logic [39:0] ROWS [7] = '{
      {8'd0,  8'd0,  8'd0, 8'h00, 8'h04},
      {8'd0,  8'd0,  8'd0, 8'h01, 8'h10},
      {8'd0,  8'd9,  8'd0, 8'h00, 8'hFF},
      {8'd3,  8'd0,  8'd0, 8'h07, 8'h02},
      {8'd10, 8'd0,  8'd0, 8'h00, 8'h08},
      {8'd0,  8'd10, 8'd0, 8'h00, 8'h01},
      {8'd0,  8'd0,  8'd1, 8'h00, 8'h01}};

   logic clk = 1'b0, rst_n = 1'b0, glue_en = 1'b0;
   logic line_en, scl, sda, speed_4m, cfg_done;
   logic [15:0] ram_kb;
   logic [47:0] station;
   logic [2:0]  ferr;
   logic m_low = 1'b0;
   wire  sda_in = (line_en ? sda : 1'b1) & ~m_low;
   always #4 clk = ~clk;

   seeprom_cfg_loader #(.SETTLE_CYCLES(TB_SETTLE), .SPEED_ADDR(SP_A), .RAM_ADDR(RAM_A),
                        .ADDR_BASE(MAC_A)) u0 (
      .clk(clk), .rst_n(rst_n), .glue_en(glue_en), .sda_i(sda_in), .line_en_o(line_en),
      .scl_o(scl), .sda_o(sda), .speed_4m_o(speed_4m), .ram_kb_o(ram_kb),
      .station_addr_o(station), .field_err_o(ferr), .cfg_done_o(cfg_done));

   int total = 0, fails = 0;
   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural EEPROM
   int refuse = 0, withhold = 0, stuck = 0;
   logic [7:0] m_sp = 0, m_ram = 0, m_seed = 0;
   function automatic logic [7:0] mem_rd(input logic [7:0] a);
      if (a == SP_A) return m_sp;
      if (a == RAM_A) return m_ram;
      if (a >= MAC_A && a < MAC_A + 8'd6) return m_seed + (a - MAC_A);
      return 8'h5A;
   endfunction
   logic pscl = 1'b0, psda = 1'b1, acked = 1'b0, ack_en = 1'b0, kind = 1'b0;
   int mph = 0, mcnt = 0, slot = 0, ncap = 0;
   logic [7:0] sh = 0, maddr = 0;
   logic [7:0] cap [3];
   always @(negedge clk) begin
      if (!rst_n) begin
         mph = 0; m_low = 1'b0; ncap = 0;
      end else if (line_en) begin
         if (scl && pscl && psda && !sda) begin
            mph = 1; mcnt = 0; kind = 1'b0; m_low = 1'b0;
         end else if (scl && !pscl) begin
            if (mph == 1) begin sh = {sh[6:0], sda}; mcnt++; end
            else if (mph == 2 && m_low) acked = 1'b1;
            else if (mph == 3) mcnt++;
         end else if (!scl && pscl) begin
            if (mph == 1 && mcnt == 8) begin
               if (ncap < 3) begin cap[ncap] = sh; ncap++; end
               mph = 2; slot = 0; acked = 1'b0;
               if (!kind && refuse > 0) begin ack_en = 1'b0; refuse--; end
               else ack_en = 1'b1;
               m_low = ack_en && (withhold == 0);
            end else if (mph == 2) begin
               if (acked) begin
                  m_low = 1'b0;
                  if (kind) begin maddr = sh; mph = 1; mcnt = 0; kind = 1'b0; end
                  else if (sh[0]) begin mph = 3; mcnt = 0; m_low = !mem_rd(maddr)[7]; end
                  else begin mph = 1; mcnt = 0; kind = 1'b1; end
               end else begin
                  slot++;
                  m_low = ack_en && (slot >= withhold);
               end
            end else if (mph == 3) begin
               if (mcnt < 8) m_low = !mem_rd(maddr)[7 - mcnt];
               else begin m_low = (stuck != 0); mph = 4; end
            end
         end
      end
      pscl = scl; psda = sda;
   end

   // line monitor
   logic [2:0] plines = 3'b001;
   int gap = 0, min_gap = 1000, en_bad = 0, nchg = 0, done_cnt = 0;
   logic [2:0] first4 [4];
   always @(negedge clk) begin
      if (!rst_n) begin
         plines = 3'b001; gap = 0; nchg = 0;
      end else begin
         gap++;
         if ({line_en, scl, sda} != plines) begin
            if (!line_en) en_bad++;
            if (nchg > 0 && gap < min_gap) min_gap = gap;
            if (nchg < 4) first4[nchg] = {line_en, scl, sda};
            nchg++; gap = 0;
            plines = {line_en, scl, sda};
         end
         if (cfg_done) done_cnt++;
      end
   end

   task automatic do_reset();
      glue_en = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_load();
      done_cnt = 0;
      glue_en = 1'b1;
      for (int c = 0; c < 40000 && done_cnt == 0; c++) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 reset en", line_en, 0);
      chk("R1 reset scl", scl, 0);
      chk("R1 reset sda", sda, 1);
      repeat (300) @(negedge clk);
      chk("R12 idle before glue_en", nchg, 0);

      for (int r = 0; r < 7; r++) begin
         logic [39:0] row;
         logic fail_all, sp_fail;
         logic [7:0] esp, eram;
         logic [47:0] emac;
         logic [2:0] eerr;
         string tg;
         row = ROWS[r];
         if (r > 0) do_reset();
         refuse = int'(row[39:32]); withhold = int'(row[31:24]); stuck = int'(row[23:16]);
         m_sp = row[15:8]; m_ram = row[7:0]; m_seed = 8'h21 + 8'(r * 16);
         fail_all = (row[31:24] >= 8'd10) || (row[23:16] != 0);
         sp_fail  = fail_all || (row[39:32] >= 8'd10);
         esp  = sp_fail ? 8'hFF : row[15:8];
         eram = fail_all ? 8'hFF : row[7:0];
         for (int i = 0; i < 6; i++)
            emac[8*(5-i) +: 8] = fail_all ? 8'hFF : m_seed + 8'(i);
         eerr = {fail_all, fail_all, sp_fail};
         tg = (row[31:24] != 0) ? "R6 ack slots" : (row[39:32] != 0) ? "R7 retries" :
              (row[23:16] != 0) ? "R8 nack" : "R5 receive";
         run_load();
         chk($sformatf("R9 row%0d speed", r), speed_4m, esp != 8'h00);
         chk($sformatf("R10 row%0d ram_kb", r), ram_kb, 16'(eram) * 16'd128);
         chk($sformatf("R11 row%0d station", r), station, emac);
         chk($sformatf("%s R8 row%0d errors", tg, r), ferr, eerr);
         chk($sformatf("R12 row%0d done pulses", r), done_cnt, 1);
         if (r == 0) begin
            // R3 start order, R4 command bytes, R2 spacing
            chk("R3 start write 1", first4[0], 3'b101);
            chk("R3 start write 2", first4[1], 3'b111);
            chk("R3 start write 3", first4[2], 3'b110);
            chk("R3 start write 4", first4[3], 3'b101);
            chk("R4 write command", cap[0], 8'hA0);
            chk("R4 word address", cap[1], SP_A);
            chk("R4 read command", cap[2], 8'hA1);
            chk("R2 min hold", min_gap, TB_SETTLE + 1);
            chk("R1 enable on change", en_bad, 0);
            nchg = 0;
            repeat (500) @(negedge clk);
            chk("R12 no restart", nchg + done_cnt, 1);
         end
      end
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule